// File: doc/BRIEF.md
# Load/Store Address Generator

This unit forms the memory address for a single-register load or store. Each issued operation supplies a base register value and its index, the address of the instruction itself, and an offset. The offset is either a zero-extended immediate or a register value passed through a barrel shifter. A direction flag selects whether the offset is added to or subtracted from the base. When the base index names the program counter, the base is replaced by the instruction address plus a fixed prefetch distance.

A pre/post flag decides whether the access goes to the adjusted address or to the unmodified base. The adjusted address is always offered as the write-back value for the base register, and it is enabled when the operation asks for it. An encoding that asks for write-back into a register that is also the transfer destination is rejected: the unit raises an illegal flag and suppresses both the access and the write-back. A legal load into the program counter raises a pipeline flush request.

Results appear on registered outputs one clock after the operation is issued. The memory bus and the data path sit outside the block.

Top module: `lsag_top`

## Requirements
- R1: When `base_idx` equals PC_IDX (default 15), the base used is `insn_addr + PC_AHEAD` (default 8), and `base_val` is ignored.
- R2: When `ofs_use_reg` is 0, the offset is `ofs_imm` zero-extended to AW bits. When it is 1, the offset is `ofs_reg` shifted by `sh_amt` according to `sh_type`: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. An amount of 0 leaves the value unchanged.
- R3: The adjusted address is base + offset when `ofs_add` is 1 and base − offset when it is 0, both wrapping modulo 2^AW.
- R4: With `pre_idx` at 1, `acc_addr` is the adjusted address. With `pre_idx` at 0, `acc_addr` is the unmodified base (after R1).
- R5: `wb_val` carries the adjusted address. `wb_en` is 1 for a legal issued operation with `wb_req` at 1, and 0 otherwise.
- R6: An issued operation with `wb_req` at 1 and `dst_idx` equal to `base_idx` raises `illegal` and forces `acc_vld`, `wb_en` and `flush_req` to 0. Equal indices without write-back are legal.
- R7: `acc_byte` follows `is_byte` (1 = one byte, 0 = one 32-bit word), and `acc_load` follows `is_load` (1 = load, 0 = store).
- R8: `flush_req` is 1 exactly for a legal issued load whose `dst_idx` equals PC_IDX. A store to that index does not flush.
- R9: Outputs reflect the operation issued at the previous rising clock edge. A cycle without `issue_vld` yields `acc_vld`, `wb_en`, `illegal` and `flush_req` all 0.
- R10: While `rst_n` is low, `acc_vld`, `wb_en`, `illegal` and `flush_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | An operation is presented this cycle |
| base_val | input | AW | Base register contents |
| base_idx | input | IW | Base register index |
| insn_addr | input | AW | Address of the issuing instruction |
| ofs_imm | input | IMM_W | Immediate offset |
| ofs_use_reg | input | 1 | 1 = register offset, 0 = immediate |
| ofs_reg | input | AW | Offset register contents |
| sh_type | input | 2 | Shift kind for the register offset |
| sh_amt | input | SHW | Shift amount |
| ofs_add | input | 1 | 1 = add offset, 0 = subtract |
| pre_idx | input | 1 | 1 = access adjusted address, 0 = access base |
| wb_req | input | 1 | Base write-back requested |
| is_load | input | 1 | 1 = load, 0 = store |
| is_byte | input | 1 | 1 = byte transfer, 0 = word |
| dst_idx | input | IW | Transfer register index |
| acc_vld | output | 1 | Access request |
| acc_addr | output | AW | Access address |
| acc_load | output | 1 | Access direction |
| acc_byte | output | 1 | Access width |
| wb_en | output | 1 | Base write-back enable |
| wb_val | output | AW | Base write-back value |
| illegal | output | 1 | Rejected encoding |
| flush_req | output | 1 | Pipeline flush request |

## Verification
The address path is driven with immediate offsets in both directions and with register offsets through every shift kind, including a rotate by zero and an all-ones immediate. Comparing these results shows whether the shift kinds and the add/subtract direction are decoded correctly. Pre- and post-indexed cases that carry the same offset show which address reaches the access port and which reaches the write-back port. Program-counter bases, including one that is post-indexed, separate the prefetch substitution from the ordinary base. Wrapping sums at both ends of the address space expose carry or borrow mishandling. Directed cases then pit illegal write-back encodings, one of them a program-counter load, against legal same-index transfers, idle cycles and a reset that lands while a result is pending.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

   typedef enum logic [1:0] {
      SH_LSL = 2'd0,
      SH_LSR = 2'd1,
      SH_ASR = 2'd2,
      SH_ROR = 2'd3
   } shift_e;

   typedef struct packed {
      logic acc;
      logic wb;
      logic bad;
      logic flush;
   } lsag_ctl_t;

endpackage

// File: rtl/lsag_ofs_shift.sv
module lsag_ofs_shift
   import lsag_pkg::*;
#(
   parameter int AW       = 32,
   parameter int SHW      = 5,
   parameter bit SHIFT_EN = 1'b1
) (
   input  logic [AW-1:0]  val,
   input  logic [1:0]     kind,
   input  logic [SHW-1:0] amt,
   output logic [AW-1:0]  res
);

   generate
      if (SHIFT_EN) begin : g_shift
         logic [2*AW-1:0] rot_w;
         always_comb begin
            rot_w = {val, val} >> amt;
            unique case (shift_e'(kind))
               SH_LSL:  res = val << amt;
               SH_LSR:  res = val >> amt;
               SH_ASR:  res = $unsigned($signed(val) >>> amt);
               default: res = rot_w[AW-1:0];
            endcase
         end
      end else begin : g_pass
         logic unused_shift;
         assign unused_shift = ^{kind, amt};
         assign res = val;
      end
   endgenerate

endmodule

// File: rtl/lsag_addr_calc.sv
module lsag_addr_calc #(
   parameter int AW       = 32,
   parameter int IW       = 4,
   parameter int PC_IDX   = 15,
   parameter int PC_AHEAD = 8
) (
   input  logic [AW-1:0] base_val,
   input  logic [IW-1:0] base_idx,
   input  logic [AW-1:0] insn_addr,
   input  logic [AW-1:0] ofs,
   input  logic          ofs_add,
   input  logic          pre_idx,
   output logic [AW-1:0] acc_addr,
   output logic [AW-1:0] adj_addr
);

   localparam logic [IW-1:0] PC_SEL = IW'(PC_IDX);
   localparam logic [AW-1:0] AHEAD  = AW'(PC_AHEAD);

   logic [AW-1:0] base_eff;

   always_comb begin
      base_eff = (base_idx == PC_SEL) ? insn_addr + AHEAD : base_val;
      adj_addr = ofs_add ? base_eff + ofs : base_eff - ofs;
      acc_addr = pre_idx ? adj_addr : base_eff;
   end

endmodule

// File: rtl/lsag_ctrl.sv
module lsag_ctrl
   import lsag_pkg::*;
#(
   parameter int IW     = 4,
   parameter int PC_IDX = 15
) (
   input  logic          issue_vld,
   input  logic          wb_req,
   input  logic          is_load,
   input  logic [IW-1:0] base_idx,
   input  logic [IW-1:0] dst_idx,
   output lsag_ctl_t     ctl
);

   localparam logic [IW-1:0] PC_SEL = IW'(PC_IDX);

   always_comb begin
      ctl.bad   = issue_vld && wb_req && (dst_idx == base_idx);
      ctl.acc   = issue_vld && !ctl.bad;
      ctl.wb    = ctl.acc && wb_req;
      ctl.flush = ctl.acc && is_load && (dst_idx == PC_SEL);
   end

endmodule

// File: rtl/lsag_top.sv
module lsag_top
   import lsag_pkg::*;
#(
   parameter int AW       = 32,
   parameter int IW       = 4,
   parameter int IMM_W    = 12,
   parameter int PC_IDX   = 15,
   parameter int PC_AHEAD = 8,
   parameter bit SHIFT_EN = 1'b1,
   localparam int SHW     = $clog2(AW)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue_vld,
   input  logic [AW-1:0]    base_val,
   input  logic [IW-1:0]    base_idx,
   input  logic [AW-1:0]    insn_addr,
   input  logic [IMM_W-1:0] ofs_imm,
   input  logic             ofs_use_reg,
   input  logic [AW-1:0]    ofs_reg,
   input  logic [1:0]       sh_type,
   input  logic [SHW-1:0]   sh_amt,
   input  logic             ofs_add,
   input  logic             pre_idx,
   input  logic             wb_req,
   input  logic             is_load,
   input  logic             is_byte,
   input  logic [IW-1:0]    dst_idx,
   output logic             acc_vld,
   output logic [AW-1:0]    acc_addr,
   output logic             acc_load,
   output logic             acc_byte,
   output logic             wb_en,
   output logic [AW-1:0]    wb_val,
   output logic             illegal,
   output logic             flush_req
);

   generate
      if (AW < 8) begin : g_bad_aw
         $error("lsag_top: AW must be at least 8");
      end
      if (IMM_W >= AW || IMM_W < 1) begin : g_bad_imm
         $error("lsag_top: IMM_W must lie in 1..AW-1");
      end
      if (PC_IDX >= (1 << IW)) begin : g_bad_pc
         $error("lsag_top: PC_IDX does not fit in IW bits");
      end
   endgenerate

   logic [AW-1:0] shifted_w;
   logic [AW-1:0] ofs_w;
   logic [AW-1:0] acc_addr_w;
   logic [AW-1:0] adj_addr_w;
   lsag_ctl_t     ctl_w;

   lsag_ofs_shift #(
      .AW       (AW),
      .SHW      (SHW),
      .SHIFT_EN (SHIFT_EN)
   ) u_shift (
      .val  (ofs_reg),
      .kind (sh_type),
      .amt  (sh_amt),
      .res  (shifted_w)
   );

   assign ofs_w = ofs_use_reg ? shifted_w : {{(AW-IMM_W){1'b0}}, ofs_imm};

   lsag_addr_calc #(
      .AW       (AW),
      .IW       (IW),
      .PC_IDX   (PC_IDX),
      .PC_AHEAD (PC_AHEAD)
   ) u_addr (
      .base_val  (base_val),
      .base_idx  (base_idx),
      .insn_addr (insn_addr),
      .ofs       (ofs_w),
      .ofs_add   (ofs_add),
      .pre_idx   (pre_idx),
      .acc_addr  (acc_addr_w),
      .adj_addr  (adj_addr_w)
   );

   lsag_ctrl #(
      .IW     (IW),
      .PC_IDX (PC_IDX)
   ) u_ctrl (
      .issue_vld (issue_vld),
      .wb_req    (wb_req),
      .is_load   (is_load),
      .base_idx  (base_idx),
      .dst_idx   (dst_idx),
      .ctl       (ctl_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_vld   <= 1'b0;
         wb_en     <= 1'b0;
         illegal   <= 1'b0;
         flush_req <= 1'b0;
         acc_addr  <= '0;
         wb_val    <= '0;
         acc_load  <= 1'b0;
         acc_byte  <= 1'b0;
      end else begin
         acc_vld   <= ctl_w.acc;
         wb_en     <= ctl_w.wb;
         illegal   <= ctl_w.bad;
         flush_req <= ctl_w.flush;
         acc_addr  <= acc_addr_w;
         wb_val    <= adj_addr_w;
         acc_load  <= is_load;
         acc_byte  <= is_byte;
      end
   end

endmodule

// File: rtl/lsag_chk.sv
module lsag_chk #(
   parameter int AW       = 32,
   parameter int IW       = 4,
   parameter int PC_IDX   = 15,
   parameter int PC_AHEAD = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          issue_vld,
   input logic [AW-1:0] base_val,
   input logic [IW-1:0] base_idx,
   input logic [AW-1:0] insn_addr,
   input logic          pre_idx,
   input logic          wb_req,
   input logic [IW-1:0] dst_idx,
   input logic          acc_vld,
   input logic [AW-1:0] acc_addr,
   input logic          acc_load,
   input logic          wb_en,
   input logic          illegal,
   input logic          flush_req
);

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_vld |=> (!acc_vld && !wb_en && !illegal && !flush_req));

   // R6
   illegal_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!acc_vld && !wb_en && !flush_req));

   // R6
   illegal_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_vld && wb_req && (dst_idx == base_idx)) |=> illegal);

   // R8
   flush_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |-> (acc_vld && acc_load));

   // R4
   post_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_vld && !pre_idx && !(wb_req && (dst_idx == base_idx))
       && (base_idx != IW'(PC_IDX)))
      |=> (acc_addr == $past(base_val)));

   // R1
   pc_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_vld && !pre_idx && !(wb_req && (dst_idx == base_idx))
       && (base_idx == IW'(PC_IDX)))
      |=> (acc_addr == $past(insn_addr) + AW'(PC_AHEAD)));

endmodule

bind lsag_top lsag_chk #(
   .AW       (AW),
   .IW       (IW),
   .PC_IDX   (PC_IDX),
   .PC_AHEAD (PC_AHEAD)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .issue_vld (issue_vld),
   .base_val  (base_val),
   .base_idx  (base_idx),
   .insn_addr (insn_addr),
   .pre_idx   (pre_idx),
   .wb_req    (wb_req),
   .dst_idx   (dst_idx),
   .acc_vld   (acc_vld),
   .acc_addr  (acc_addr),
   .acc_load  (acc_load),
   .wb_en     (wb_en),
   .illegal   (illegal),
   .flush_req (flush_req)
);

// File: tb/tb_lsag_top.sv
module tb_lsag_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_vld = 1'b0;
   logic [31:0] base_val = '0;
   logic [3:0]  base_idx = '0;
   logic [31:0] insn_addr = '0;
   logic [11:0] ofs_imm = '0;
   logic        ofs_use_reg = 1'b0;
   logic [31:0] ofs_reg = '0;
   logic [1:0]  sh_type = '0;
   logic [4:0]  sh_amt = '0;
   logic        ofs_add = 1'b0;
   logic        pre_idx = 1'b0;
   logic        wb_req = 1'b0;
   logic        is_load = 1'b0;
   logic        is_byte = 1'b0;
   logic [3:0]  dst_idx = '0;
   logic        acc_vld;
   logic [31:0] acc_addr;
   logic        acc_load;
   logic        acc_byte;
   logic        wb_en;
   logic [31:0] wb_val;
   logic        illegal;
   logic        flush_req;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   lsag_top dut (
      .clk (clk), .rst_n (rst_n), .issue_vld (issue_vld),
      .base_val (base_val), .base_idx (base_idx), .insn_addr (insn_addr),
      .ofs_imm (ofs_imm), .ofs_use_reg (ofs_use_reg), .ofs_reg (ofs_reg),
      .sh_type (sh_type), .sh_amt (sh_amt), .ofs_add (ofs_add),
      .pre_idx (pre_idx), .wb_req (wb_req), .is_load (is_load),
      .is_byte (is_byte), .dst_idx (dst_idx),
      .acc_vld (acc_vld), .acc_addr (acc_addr), .acc_load (acc_load),
      .acc_byte (acc_byte), .wb_en (wb_en), .wb_val (wb_val),
      .illegal (illegal), .flush_req (flush_req)
   );

   typedef struct packed {
      logic [31:0] base;
      logic [3:0]  bidx;
      logic [31:0] pc;
      logic [11:0] imm;
      logic        use_reg;
      logic [31:0] oreg;
      logic [1:0]  sht;
      logic [4:0]  sha;
      logic        add;
      logic        pre;
      logic        wb;
      logic        ld;
      logic [3:0]  didx;
      logic        byt;
      logic [31:0] e_addr;
      logic [31:0] e_wb;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      // R3 R4 pre add
      '{32'h1000, 4'd2, 32'h0, 12'h010, 1'b0, 32'h0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd3, 1'b0, 32'h1010, 32'h1010},
      // R3 R5 pre sub with write-back
      '{32'h1000, 4'd2, 32'h0, 12'h010, 1'b0, 32'h0, 2'd0, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd4, 1'b0, 32'h0FF0, 32'h0FF0},
      // R4 R5 R7 post with write-back, byte
      '{32'h2000, 4'd5, 32'h0, 12'h008, 1'b0, 32'h0, 2'd0, 5'd0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd6, 1'b1, 32'h2000, 32'h2008},
      // R1 program-counter base
      '{32'hDEAD, 4'd15, 32'h100, 12'h004, 1'b0, 32'h0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd1, 1'b0, 32'h010C, 32'h010C},
      // R2 LSL 4
      '{32'h400, 4'd3, 32'h0, 12'h000, 1'b1, 32'h3, 2'd0, 5'd4, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2, 1'b0, 32'h0430, 32'h0430},
      // R2 LSR 31
      '{32'h10, 4'd3, 32'h0, 12'h000, 1'b1, 32'h80000000, 2'd1, 5'd31, 1'b0, 1'b1, 1'b0, 1'b1, 4'd2, 1'b0, 32'h000F, 32'h000F},
      // R2 ASR 4, store byte
      '{32'h0, 4'd3, 32'h0, 12'h000, 1'b1, 32'h80000000, 2'd2, 5'd4, 1'b1, 1'b1, 1'b0, 1'b0, 4'd2, 1'b1, 32'hF8000000, 32'hF8000000},
      // R2 ROR 4, post write-back
      '{32'h0, 4'd7, 32'h0, 12'h000, 1'b1, 32'h000000F1, 2'd3, 5'd4, 1'b1, 1'b0, 1'b1, 1'b1, 4'd2, 1'b0, 32'h0, 32'h1000000F},
      // R3 wrap upward
      '{32'hFFFFFFF0, 4'd1, 32'h0, 12'h020, 1'b0, 32'h0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd2, 1'b0, 32'h0010, 32'h0010},
      // R3 wrap downward
      '{32'h4, 4'd1, 32'h0, 12'h008, 1'b0, 32'h0, 2'd0, 5'd0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd2, 1'b0, 32'hFFFFFFFC, 32'hFFFFFFFC},
      // R8 load into program counter
      '{32'h500, 4'd1, 32'h0, 12'h000, 1'b0, 32'h0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd15, 1'b0, 32'h0500, 32'h0500},
      // R8 store from program counter: no flush
      '{32'h600, 4'd1, 32'h0, 12'h000, 1'b0, 32'h0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd15, 1'b1, 32'h0600, 32'h0600},
      // R2 rotate by zero
      '{32'h0, 4'd1, 32'h0, 12'h000, 1'b1, 32'h12345678, 2'd3, 5'd0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2, 1'b0, 32'h12345678, 32'h12345678},
      // R2 full immediate is zero-extended
      '{32'h0, 4'd1, 32'h0, 12'hFFF, 1'b0, 32'h0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2, 1'b0, 32'h0FFF, 32'h0FFF},
      // R1 R4 program-counter base, post, sub, write-back
      '{32'h0, 4'd15, 32'h200, 12'h010, 1'b0, 32'h0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2, 1'b0, 32'h0208, 32'h01F8}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      base_val    = v.base;
      base_idx    = v.bidx;
      insn_addr   = v.pc;
      ofs_imm     = v.imm;
      ofs_use_reg = v.use_reg;
      ofs_reg     = v.oreg;
      sh_type     = v.sht;
      sh_amt      = v.sha;
      ofs_add     = v.add;
      pre_idx     = v.pre;
      wb_req      = v.wb;
      is_load     = v.ld;
      dst_idx     = v.didx;
      is_byte     = v.byt;
      issue_vld   = 1'b1;
      @(negedge clk);
      issue_vld   = 1'b0;
   endtask

   function automatic vec_t mk(input logic [3:0] b, input logic [3:0] d,
                               input logic w, input logic l);
      vec_t v;
      v = '0;
      v.base = 32'h800; v.bidx = b; v.imm = 12'h4; v.add = 1'b1;
      v.pre = 1'b1; v.wb = w; v.ld = l; v.didx = d;
      return v;
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 acc_vld in reset", {31'b0, acc_vld}, 32'h0);
      check("R10 wb_en/illegal/flush in reset", {29'b0, wb_en, illegal, flush_req}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 idle after reset
      check("R9 idle outputs", {28'b0, acc_vld, wb_en, illegal, flush_req}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         check($sformatf("R2/R3/R4 access address v%0d", i), acc_addr, VECS[i].e_addr);
         check($sformatf("R5 write-back value v%0d", i), wb_val, VECS[i].e_wb);
         check($sformatf("R5/R9 acc_vld,wb_en v%0d", i), {30'b0, acc_vld, wb_en},
               {30'b0, 1'b1, VECS[i].wb});
         check($sformatf("R7 load,byte v%0d", i), {30'b0, acc_load, acc_byte},
               {30'b0, VECS[i].ld, VECS[i].byt});
         check($sformatf("R8/R6 flush,illegal v%0d", i), {30'b0, flush_req, illegal},
               {30'b0, VECS[i].ld && (VECS[i].didx == 4'd15), 1'b0});
      end

      // R6 illegal write-back to the transfer register
      drive(mk(4'd4, 4'd4, 1'b1, 1'b1));
      check("R6 illegal raised, acc/wb/flush low", {28'b0, illegal, acc_vld, wb_en, flush_req}, 32'h8);
      // R9 idle cycle clears everything
      @(negedge clk);
      check("R9 idle after illegal", {28'b0, illegal, acc_vld, wb_en, flush_req}, 32'h0);
      // R6 R8 illegal load into program counter with program-counter base: no flush
      drive(mk(4'd15, 4'd15, 1'b1, 1'b1));
      check("R6 illegal pc load, no flush", {28'b0, illegal, acc_vld, wb_en, flush_req}, 32'h8);
      // R6 same index without write-back is legal
      drive(mk(4'd4, 4'd4, 1'b0, 1'b0));
      check("R6 same index no wb legal", {28'b0, illegal, acc_vld, wb_en, flush_req}, 32'h4);
      check("R6 same index address", acc_addr, 32'h804);
      // R10 reset while a result is pending
      base_val = 32'h800; base_idx = 4'd1; dst_idx = 4'd15; is_load = 1'b1;
      wb_req = 1'b1; pre_idx = 1'b1; ofs_use_reg = 1'b0; issue_vld = 1'b1;
      rst_n = 1'b0;
      @(negedge clk);
      issue_vld = 1'b0;
      check("R10 reset suppresses issue", {28'b0, illegal, acc_vld, wb_en, flush_req}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      summary();
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

endmodule